// File: doc/BRIEF.md
# Two-Slot Toggle-Pointer Clock-Crossing FIFO

This block carries data words from a producer running on one clock to a consumer running on an unrelated clock. Storage is two word registers. Each side keeps a single-bit pointer that both names the register it touches next and records how many transfers it has made, counted modulo two. Each side sends its pointer to the other side through a two-stage flip-flop synchronizer. Each side then decides whether it may act by comparing its own pointer with the synchronized copy of the other side's pointer.

The producer raises `put_i` with a word on `put_data_i`. The word is taken on the write clock edge where `put_rdy_o` is high. The consumer watches `get_rdy_o`. While it is high, `get_data_o` shows the oldest unread word, and raising `get_i` consumes that word on the read clock edge. A side is blocked as soon as it acts and stays blocked until the other side's pointer has crossed back, so at most one word is ever outstanding. The writer therefore never fills the register the reader is looking at.

Each side is a two-state machine whose states are the slots: SLOT_A (pointer 0) and SLOT_B (pointer 1). The transition ACCEPT (writer) or CONSUME (reader) moves the side to the other slot. It fires only when the side's request and ready are both high. With no firing, the side stays in its slot (transition HOLD). Each clock domain has its own active-low reset. Reset returns that side to SLOT_A and clears its synchronizer.

Top module: `dual_slot_cdc_fifo`

## Requirements
- R1: After both resets, `put_rdy_o` is 1 and `get_rdy_o` is 0.
- R2: A put while `put_rdy_o` is 0 has no effect: no word is stored, and no extra or altered word ever appears at the read side.
- R3: On the write clock edge after an accepted put, `put_rdy_o` is 0. While `put_rdy_o` is 1, no accepted word is left unread.
- R4: After an accepted put, `get_rdy_o` rises within 4 read clock cycles.
- R5: While `get_rdy_o` is 1, `get_data_o` equals the oldest unread word and holds steady until that word is consumed.
- R6: A get while `get_rdy_o` is 0 has no effect: the read pointer does not move and `get_rdy_o` stays 0 while nothing is unread.
- R7: On the read clock edge after a consuming get, `get_rdy_o` is 0.
- R8: After a consuming get, `put_rdy_o` rises within 4 write clock cycles.
- R9: Words leave in the order they were accepted, each exactly once, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side active-low reset |
| put_i | input | 1 | Producer offers a word |
| put_data_i | input | DATA_W | Offered word |
| put_rdy_o | output | 1 | Write side may accept a word |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side active-low reset |
| get_i | input | 1 | Consumer takes the shown word |
| get_rdy_o | output | 1 | An unread word is shown |
| get_data_o | output | DATA_W | Oldest unread word |

## Verification
Suppose a side moves its pointer without a legal fire, or a synchronizer passes the wrong value. Within about three cycles of the other clock, that side's peer computes the wrong ready level. The port result is then a ready flag raised with nothing pending, a word shown twice, or a stuck handshake. Suppose instead a write lands in the slot the reader is showing. `get_data_o` then changes while `get_rdy_o` is high, or on the next read it differs from the word the reference queue expects. The bench compares the ports with a queue model on every cycle of both clocks. It also bounds how long either side may remain blocked.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
    localparam int unsigned SLOTS = 2;
    localparam int unsigned SLOT_AW = $clog2(SLOTS);

    typedef enum logic [SLOT_AW-1:0] {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } slot_e;
endpackage

// File: rtl/dsf_sync.sv
module dsf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsf_slots.sv
module dsf_slots
    import dsf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              wclk,
    input  logic              wen_i,
    input  slot_e             waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  slot_e             raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge wclk) begin
            if (wen_i && (waddr_i == slot_e'(s))) mem_q[s] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dsf_toggle_side.sv
module dsf_toggle_side
    import dsf_pkg::*;
#(
    parameter bit READY_ON_MATCH = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_i,
    input  logic  peer_i,
    output slot_e slot_o,
    output logic  rdy_o,
    output logic  fire_o
);
    slot_e state_q, state_d;
    logic  match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_A;
        else        state_q <= state_d;
    end

    always_comb begin
        match   = 1'b0;
        state_d = state_q;
        unique case (state_q)
            SLOT_A: match = !peer_i;
            SLOT_B: match = peer_i;
        endcase
        if (READY_ON_MATCH) rdy_o = match;
        else                rdy_o = !match;
        fire_o = req_i && rdy_o;
        if (fire_o) begin
            unique case (state_q)
                SLOT_A: state_d = SLOT_B;
                SLOT_B: state_d = SLOT_A;
            endcase
        end
    end

    assign slot_o = state_q;
endmodule

// File: rtl/dual_slot_cdc_fifo.sv
module dual_slot_cdc_fifo
    import dsf_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              put_i,
    input  logic [DATA_W-1:0] put_data_i,
    output logic              put_rdy_o,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              get_i,
    output logic              get_rdy_o,
    output logic [DATA_W-1:0] get_data_o
);
    slot_e wptr, rptr;
    logic  wptr_at_r, rptr_at_w;
    logic  wr_fire, rd_fire;

    dsf_toggle_side #(.READY_ON_MATCH(1'b1)) u_wside (
        .clk(wclk), .rst_n(wrst_n), .req_i(put_i), .peer_i(rptr_at_w),
        .slot_o(wptr), .rdy_o(put_rdy_o), .fire_o(wr_fire)
    );

    dsf_toggle_side #(.READY_ON_MATCH(1'b0)) u_rside (
        .clk(rclk), .rst_n(rrst_n), .req_i(get_i), .peer_i(wptr_at_r),
        .slot_o(rptr), .rdy_o(get_rdy_o), .fire_o(rd_fire)
    );

    dsf_sync #(.STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d_i(wptr[0]), .q_o(wptr_at_r)
    );

    dsf_sync #(.STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d_i(rptr[0]), .q_o(rptr_at_w)
    );

    dsf_slots #(.DATA_W(DATA_W)) u_slots (
        .wclk(wclk), .wen_i(wr_fire), .waddr_i(wptr), .wdata_i(put_data_i),
        .raddr_i(rptr), .rdata_o(get_data_o)
    );
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              wclk,
    input logic              wrst_n,
    input logic              rclk,
    input logic              rrst_n,
    input logic              put_i,
    input logic              put_rdy_o,
    input logic              get_i,
    input logic              get_rdy_o,
    input logic [DATA_W-1:0] get_data_o,
    input logic              wptr_bit,
    input logic              rptr_bit
);
    // R2: a blocked writer keeps its slot
    a_r2_blocked_put: assert property (@(posedge wclk) disable iff (!wrst_n)
        !put_rdy_o |=> $stable(wptr_bit));

    // R3: an accepted put blocks the writer on the next edge
    a_r3_put_blocks: assert property (@(posedge wclk) disable iff (!wrst_n)
        (put_i && put_rdy_o) |=> !put_rdy_o);

    // R5: the shown word holds until consumed
    a_r5_data_holds: assert property (@(posedge rclk) disable iff (!rrst_n)
        (get_rdy_o && !get_i) |=> (get_rdy_o && $stable(get_data_o)));

    // R6: a get while empty leaves the read slot alone
    a_r6_blocked_get: assert property (@(posedge rclk) disable iff (!rrst_n)
        !get_rdy_o |=> $stable(rptr_bit));

    // R7: a consuming get clears read-ready on the next edge
    a_r7_get_blocks: assert property (@(posedge rclk) disable iff (!rrst_n)
        (get_i && get_rdy_o) |=> !get_rdy_o);
endmodule

bind dual_slot_cdc_fifo dsf_checker #(.DATA_W(DATA_W)) u_chk (
    .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
    .put_i(put_i), .put_rdy_o(put_rdy_o), .get_i(get_i),
    .get_rdy_o(get_rdy_o), .get_data_o(get_data_o),
    .wptr_bit(wptr[0]), .rptr_bit(rptr[0])
);

// File: tb/tb_dual_slot_cdc_fifo.sv
`timescale 1ns/1ps
module tb_dual_slot_cdc_fifo;
    localparam int DW = 8;
    localparam int WHALF = 10;   // 50 MHz write clock
    localparam int RHALF = 7;    // unrelated read clock
    localparam int LIMIT = 4;

    logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
    logic put_i = 0, get_i = 0;
    logic [DW-1:0] put_data_i = '0;
    logic put_rdy_o, get_rdy_o;
    logic [DW-1:0] get_data_o;

    always #WHALF wclk = ~wclk;
    always #RHALF rclk = ~rclk;

    dual_slot_cdc_fifo #(.DATA_W(DW), .SYNC_STAGES(2)) dut (
        .wclk(wclk), .wrst_n(wrst_n), .put_i(put_i), .put_data_i(put_data_i),
        .put_rdy_o(put_rdy_o), .rclk(rclk), .rrst_n(rrst_n), .get_i(get_i),
        .get_rdy_o(get_rdy_o), .get_data_o(get_data_o)
    );

    int checks = 0, fails = 0;
    int pushed = 0, popped = 0;
    logic [DW-1:0] model_q[$];
    bit running = 0, finished = 0;
    int rd_mode = 0;  // 0 always get, 1 random, 2 idle, 3 get held
    int w_stall = 0, r_stall = 0;
    bit last_pop = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // write-side reference model, sampled 1 ns before each write edge
    always begin
        @(negedge wclk); #(WHALF-1);
        if (running) begin
            if (put_rdy_o) chk(model_q.size() == 0, "R3 ready with word unread", model_q.size(), 0);
            if (model_q.size() == 0 && !put_rdy_o) w_stall++; else w_stall = 0;
            chk(w_stall <= LIMIT, "R8 write side stays blocked", w_stall, LIMIT);
            if (put_i && put_rdy_o) begin
                model_q.push_back(put_data_i);
                pushed++;
            end
        end
    end

    // read-side reference model, sampled 1 ns before each read edge
    always begin
        @(negedge rclk); #(RHALF-1);
        if (running) begin
            if (last_pop) chk(!get_rdy_o, "R7 ready after consume", get_rdy_o, 0);
            last_pop = 0;
            if (model_q.size() == 0)
                chk(!get_rdy_o, "R6 ready with nothing unread", get_rdy_o, 0);
            else begin
                if (!get_rdy_o) r_stall++; else r_stall = 0;
                chk(r_stall <= LIMIT, "R4 read side stays empty", r_stall, LIMIT);
                if (get_rdy_o)
                    chk(get_data_o == model_q[0], "R5 R9 shown word", get_data_o, model_q[0]);
            end
            if (get_i && get_rdy_o && model_q.size() != 0) begin
                void'(model_q.pop_front());
                popped++;
                last_pop = 1;
            end
        end
    end

    // read driver
    always begin
        @(negedge rclk); #2;
        case (rd_mode)
            0: get_i = 1'b1;
            1: get_i = ($urandom % 3) == 0;
            3: get_i = 1'b1;
            default: get_i = 1'b0;
        endcase
    end

    task automatic put_word(input logic [DW-1:0] d);
        bit done = 0;
        while (!done) begin
            @(negedge wclk); #2;
            put_i = 1'b1; put_data_i = d;
            #(WHALF-3);
            done = put_rdy_o;
        end
        @(negedge wclk); #2;
        put_i = 1'b0;
    endtask

    task automatic wait_empty();
        while (model_q.size() != 0) @(negedge wclk);
        repeat (8) @(negedge wclk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge wclk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rd_mode = 2;
        repeat (5) @(negedge wclk);
        #1;
        chk(put_rdy_o == 1, "R1 put ready in reset", put_rdy_o, 1);
        chk(get_rdy_o == 0, "R1 get ready in reset", get_rdy_o, 0);
        wrst_n = 1; rrst_n = 1;
        repeat (4) @(negedge wclk);
        #1;
        chk(put_rdy_o == 1, "R1 put ready after reset", put_rdy_o, 1);
        chk(get_rdy_o == 0, "R1 get ready after reset", get_rdy_o, 0);
        running = 1;

        // stray gets with nothing stored (R6)
        rd_mode = 3;
        repeat (20) @(negedge rclk);
        rd_mode = 2;
        repeat (4) @(negedge rclk);

        // back-to-back stream, eager reader (R9)
        rd_mode = 0;
        for (int i = 0; i < 16; i++) put_word(8'(i * 7 + 3));
        wait_empty();

        // random reader, writer with gaps
        rd_mode = 1;
        for (int i = 16; i < 40; i++) begin
            put_word(8'(i * 7 + 3));
            repeat ($urandom % 3) @(negedge wclk);
        end
        wait_empty();

        // put while blocked must be ignored (R2)
        rd_mode = 2;
        repeat (4) @(negedge rclk);
        put_word(8'h5A);
        for (int k = 0; k < 10; k++) begin
            @(negedge wclk); #2;
            put_i = 1'b1; put_data_i = 8'hEE;
            #(WHALF-3);
            chk(!put_rdy_o, "R2 writer blocked while word unread", put_rdy_o, 0);
        end
        @(negedge wclk); #2; put_i = 1'b0;
        rd_mode = 0;
        wait_empty();
        rd_mode = 2;
        repeat (10) @(negedge rclk);

        checks++;
        if (!(pushed == 41 && popped == 41 && model_q.size() == 0)) begin
            fails++;
            $display("FAIL R9 words in/out actual=%0d/%0d expected=41/41", pushed, popped);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule